// File: doc/BRIEF.md
# Compact-Mode Branch Resolver

This unit works out where execution goes next after a branch-class instruction of the 16-bit compact instruction set. Each cycle it may receive one opcode. With the opcode come the current program counter, the four arithmetic flags, the link register and one general register value. The program counter input is the instruction's own address plus 4. One clock later the unit presents four results:

- whether the branch is taken;
- the next program counter;
- an optional link register write, with its value;
- the instruction mode that should be in effect afterwards.

It handles four kinds of branch:

- flag-conditioned short branches;
- unconditional branches;
- the two-halfword long call, which carries its upper offset through the link register;
- the register-indirect branch that can switch instruction mode.

Any other opcode passes through as a non-branch, and its result is the sequential address.

A core feeds the unit from its decode stage. It writes the link value back when the link enable is set, and it redirects fetch when the taken output is set. The register-indirect branch reads its own source field. When that field names the program counter, the unit uses the program counter input and word-aligns the target. When the field names any other register, the unit uses the supplied register value.

Top module: `brtu_unit`

## Requirements
- R1: During and right after reset, out_valid, out_taken and out_link_we are low.
- R2: A request with in_valid high produces out_valid high on the following cycle only. A cycle with in_valid low produces no result.
- R3: An opcode with bits [15:12] = 1101 is a conditional branch. Its condition code is bits [11:8]. When the condition holds, out_next_pc = pc + sign-extended bits [7:0] × 2, and out_taken is high.
- R4: Condition codes 0 to 13 evaluate the flags input, where bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. The codes are:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z&(N==V)
  - 13: Z|(N!=V)
- R5: Certain cases are never taken. These are a failed condition, condition codes 14 and 15, and any opcode that is not a branch. For these, out_taken is low and out_next_pc = pc − 2, which is the next sequential halfword.
- R6: Bits [15:11] = 11100 give an unconditional branch. It is taken, with out_next_pc = pc + sign-extended bits [10:0] × 2.
- R7: Bits [15:11] = 11110 give the first long-call half. It writes the link register with pc + (sign-extended bits [10:0] << 12). It is not taken.
- R8: Bits [15:11] = 11111 give the second long-call half. It is taken, with out_next_pc = link + bits [10:0] × 2 (zero-extended). It writes link = (pc − 2) | 1.
- R9: Bits [15:7] = 010001110 give the register-indirect branch, whose source index is bits [6:3]. It is taken. The target is the source value with bit 0 cleared, and out_mode is bit 0 of the source.
- R10: If the indirect source index is 15, the pc input is the source value, and the target has bits 1 and 0 cleared.
- R11: out_mode is 1 for every result other than the register-indirect branch.
- R12: out_link_we is high only for the two long-call halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_opcode | input | 16 | Instruction halfword |
| in_pc | input | XLEN | Instruction address plus 4 |
| in_flags | input | 4 | N, Z, C, V (bits 3..0) |
| in_link | input | XLEN | Current link register |
| in_reg | input | XLEN | Register value for indirect branch |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Control flow leaves the sequential path |
| out_next_pc | output | XLEN | Next program counter |
| out_link_we | output | 1 | Link register write enable |
| out_link_val | output | XLEN | Value to write to link register |
| out_mode | output | 1 | Instruction mode after this instruction (1 = compact) |

## Verification
The hardest case to reach is an indirect branch whose source is the program counter. In that case the supplied register value must be ignored, and two low bits must be cleared instead of one. The stimulus produces it by setting the source field to 15 while the pc input has bit 1 and bit 0 set and in_reg holds an unrelated value. A wrong operand choice then shows up directly in the target.

The long-call pair is sent back to back. The link value from the first half is fed into the second, so the full-offset sum is checked across both halves. Every condition code is driven with a flag pattern that makes it hold and with one that makes it fail.

// File: rtl/brtu_pkg.sv
package brtu_pkg;
  typedef enum logic [2:0] {
    BK_NONE,
    BK_COND,
    BK_JUMP,
    BK_CALL_HI,
    BK_CALL_LO,
    BK_XCHG
  } br_kind_e;

  localparam int OPC_W  = 16;
  localparam int FLAG_W = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;
endpackage

// File: rtl/brtu_decode.sv
module brtu_decode
  import brtu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output br_kind_e         kind
);
  always_comb begin
    kind = BK_NONE;
    if (opcode[15:12] == 4'b1101 && opcode[11:9] != 3'b111)
      kind = BK_COND;
    else if (opcode[15:11] == 5'b11100)
      kind = BK_JUMP;
    else if (opcode[15:11] == 5'b11110)
      kind = BK_CALL_HI;
    else if (opcode[15:11] == 5'b11111)
      kind = BK_CALL_LO;
    else if (opcode[15:7] == 9'b010001110)
      kind = BK_XCHG;
  end
endmodule

// File: rtl/brtu_cond.sv
module brtu_cond
  import brtu_pkg::*;
(
  input  logic [3:0]        code,
  input  logic [FLAG_W-1:0] flags,
  output logic              holds
);
  logic n, z, c, v;
  assign n = flags[FN];
  assign z = flags[FZ];
  assign c = flags[FC];
  assign v = flags[FV];

  always_comb begin
    unique case (code)
      4'd0:    holds = z;
      4'd1:    holds = !z;
      4'd2:    holds = c;
      4'd3:    holds = !c;
      4'd4:    holds = n;
      4'd5:    holds = !n;
      4'd6:    holds = v;
      4'd7:    holds = !v;
      4'd8:    holds = c && !z;
      4'd9:    holds = !c || z;
      4'd10:   holds = (n == v);
      4'd11:   holds = (n != v);
      4'd12:   holds = !z && (n == v);
      4'd13:   holds = z || (n != v);
      default: holds = 1'b0;
    endcase
  end
endmodule

// File: rtl/brtu_target.sv
module brtu_target
  import brtu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e         kind,
  input  logic [OPC_W-1:0] opcode,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  link,
  input  logic [XLEN-1:0]  rval,
  input  logic             cond_ok,
  output logic             taken,
  output logic [XLEN-1:0]  next_pc,
  output logic             link_we,
  output logic [XLEN-1:0]  link_val,
  output logic             mode
);
  localparam int SHORT_W = 8;
  localparam int LONG_W  = 11;
  localparam int HI_SH   = 12;
  localparam logic [3:0] PC_IDX = 4'hF;

  logic [XLEN-1:0] seq_pc, off_short, off_long, off_hi, off_lo, xsrc, xtgt;
  logic            from_pc;

  assign seq_pc    = pc - XLEN'(2);
  assign off_short = {{(XLEN-SHORT_W-1){opcode[SHORT_W-1]}}, opcode[SHORT_W-1:0], 1'b0};
  assign off_long  = {{(XLEN-LONG_W-1){opcode[LONG_W-1]}}, opcode[LONG_W-1:0], 1'b0};
  assign off_hi    = {{(XLEN-LONG_W-HI_SH){opcode[LONG_W-1]}}, opcode[LONG_W-1:0], {HI_SH{1'b0}}};
  assign off_lo    = {{(XLEN-LONG_W-1){1'b0}}, opcode[LONG_W-1:0], 1'b0};
  assign from_pc   = (opcode[6:3] == PC_IDX);
  assign xsrc      = from_pc ? pc : rval;
  assign xtgt      = from_pc ? {xsrc[XLEN-1:2], 2'b00} : {xsrc[XLEN-1:1], 1'b0};

  always_comb begin
    taken    = 1'b0;
    next_pc  = seq_pc;
    link_we  = 1'b0;
    link_val = '0;
    mode     = 1'b1;
    unique case (kind)
      BK_COND: if (cond_ok) begin
        taken   = 1'b1;
        next_pc = pc + off_short;
      end
      BK_JUMP: begin
        taken   = 1'b1;
        next_pc = pc + off_long;
      end
      BK_CALL_HI: begin
        link_we  = 1'b1;
        link_val = pc + off_hi;
      end
      BK_CALL_LO: begin
        taken    = 1'b1;
        next_pc  = link + off_lo;
        link_we  = 1'b1;
        link_val = {seq_pc[XLEN-1:1], 1'b1};
      end
      BK_XCHG: begin
        taken   = 1'b1;
        next_pc = xtgt;
        mode    = xsrc[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brtu_unit.sv
module brtu_unit
  import brtu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [15:0]       in_opcode,
  input  logic [XLEN-1:0]   in_pc,
  input  logic [3:0]        in_flags,
  input  logic [XLEN-1:0]   in_link,
  input  logic [XLEN-1:0]   in_reg,
  output logic              out_valid,
  output logic              out_taken,
  output logic [XLEN-1:0]   out_next_pc,
  output logic              out_link_we,
  output logic [XLEN-1:0]   out_link_val,
  output logic              out_mode
);
  br_kind_e        kind;
  logic            cond_ok, t_taken, t_lwe, t_mode;
  logic [XLEN-1:0] t_next, t_lval;

  brtu_decode u_dec (.opcode(in_opcode), .kind(kind));

  brtu_cond u_cond (.code(in_opcode[11:8]), .flags(in_flags), .holds(cond_ok));

  brtu_target #(.XLEN(XLEN)) u_tgt (
    .kind(kind), .opcode(in_opcode), .pc(in_pc), .link(in_link), .rval(in_reg),
    .cond_ok(cond_ok), .taken(t_taken), .next_pc(t_next), .link_we(t_lwe),
    .link_val(t_lval), .mode(t_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_link_we  <= 1'b0;
      out_next_pc  <= '0;
      out_link_val <= '0;
      out_mode     <= 1'b1;
    end else begin
      out_valid   <= in_valid;
      out_taken   <= in_valid && t_taken;
      out_link_we <= in_valid && t_lwe;
      if (in_valid) begin
        out_next_pc  <= t_next;
        out_link_val <= t_lval;
        out_mode     <= t_mode;
      end
    end
  end
endmodule

// File: rtl/brtu_unit_chk.sv
module brtu_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [15:0]     in_opcode,
  input logic [XLEN-1:0] in_pc,
  input logic            out_valid,
  input logic            out_taken,
  input logic [XLEN-1:0] out_next_pc,
  input logic            out_link_we,
  input logic [XLEN-1:0] out_link_val,
  input logic            out_mode
);
  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R5
  seq_when_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_taken) |-> out_next_pc == $past(in_pc) - XLEN'(2));
  // R9
  xchg_even_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_opcode[15:7]) == 9'b010001110) |-> !out_next_pc[0]);
  // R10
  xchg_pc_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_opcode[15:7]) == 9'b010001110 && $past(in_opcode[6:3]) == 4'hF)
      |-> out_next_pc[1:0] == 2'b00);
  // R8
  return_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (out_link_we && $past(in_opcode[15:11]) == 5'b11111) |-> out_link_val[0]);
  // R12
  link_only_call_chk: assert property (@(posedge clk) disable iff (rst)
    out_link_we |-> (out_valid && $past(in_opcode[15:12]) == 4'hF));
  // R11
  mode_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_opcode[15:7]) != 9'b010001110) |-> out_mode);
endmodule

bind brtu_unit brtu_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode), .in_pc(in_pc),
  .out_valid(out_valid), .out_taken(out_taken), .out_next_pc(out_next_pc),
  .out_link_we(out_link_we), .out_link_val(out_link_val), .out_mode(out_mode)
);

// File: tb/sim_brtu_unit.sv
`timescale 1ns/1ps
module sim_brtu_unit;
  localparam int XLEN = 32;

  typedef struct {
    logic            taken;
    logic [XLEN-1:0] next_pc;
    logic            lwe;
    logic [XLEN-1:0] lval;
    logic            mode;
    string           req;
  } exp_t;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [15:0] in_opcode = '0;
  logic [XLEN-1:0] in_pc = '0, in_link = '0, in_reg = '0;
  logic [3:0] in_flags = '0;
  logic out_valid, out_taken, out_link_we, out_mode;
  logic [XLEN-1:0] out_next_pc, out_link_val;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  brtu_unit #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode), .in_pc(in_pc),
    .in_flags(in_flags), .in_link(in_link), .in_reg(in_reg), .out_valid(out_valid),
    .out_taken(out_taken), .out_next_pc(out_next_pc), .out_link_we(out_link_we),
    .out_link_val(out_link_val), .out_mode(out_mode)
  );

  // R4 condition table from the requirement text
  function automatic bit cond_ref(input int code, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (code)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return n == v;    11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 0;
    endcase
  endfunction

  task automatic send(input logic [15:0] op, input logic [XLEN-1:0] pc,
                      input logic [3:0] fl, input logic [XLEN-1:0] lr,
                      input logic [XLEN-1:0] rv, input exp_t e);
    @(negedge clk);
    in_valid = 1; in_opcode = op; in_pc = pc; in_flags = fl; in_link = lr; in_reg = rv;
    q.push_back(e);
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic exp_t mk(input bit t, input logic [XLEN-1:0] np, input bit w,
                              input logic [XLEN-1:0] lv, input bit m, input string r);
    exp_t e;
    e.taken = t; e.next_pc = np; e.lwe = w; e.lval = lv; e.mode = m; e.req = r;
    return e;
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && out_valid) begin
        exp_t e;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected result: actual out_valid=1 expected 0");
        end else begin
          e = q.pop_front();
          if (out_taken !== e.taken || out_next_pc !== e.next_pc || out_link_we !== e.lwe ||
              (e.lwe && out_link_val !== e.lval) || out_mode !== e.mode) begin
            errors++;
            $display("FAIL %s actual t=%0b pc=%h we=%0b lv=%h m=%0b expected t=%0b pc=%h we=%0b lv=%h m=%0b",
                     e.req, out_taken, out_next_pc, out_link_we, out_link_val, out_mode,
                     e.taken, e.next_pc, e.lwe, e.lval, e.mode);
          end
        end
      end
    end
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] lr1;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 0 || out_taken !== 0 || out_link_we !== 0) begin
      errors++;
      $display("FAIL R1 actual v=%0b t=%0b we=%0b expected 0 0 0", out_valid, out_taken, out_link_we);
    end
    rst = 0;
    repeat (2) @(negedge clk);
    // R2 idle: no result expected; monitor flags any spurious output
    // R3 R4 R5: every code with a holding and a failing flag pattern
    for (int code = 0; code < 14; code++) begin
      logic [3:0] fh = 4'h0, ff = 4'h0;
      for (int f = 0; f < 16; f++) begin
        if (cond_ref(code, 4'(f))) fh = 4'(f);
      end
      for (int f = 15; f >= 0; f--) begin
        if (!cond_ref(code, 4'(f))) ff = 4'(f);
      end
      send({4'b1101, 4'(code), 8'hFE}, 32'h100, fh, 0, 0, mk(1, 32'hFC, 0, 0, 1, "R3/R4 holds"));
      send({4'b1101, 4'(code), 8'h7F}, 32'h100, ff, 0, 0, mk(0, 32'hFE, 0, 0, 1, "R4/R5 fails"));
    end
    send(16'hD07F, 32'h1000, 4'b0100, 0, 0, mk(1, 32'h10FE, 0, 0, 1, "R3 max forward"));
    send(16'hD080, 32'h1000, 4'b0100, 0, 0, mk(1, 32'h0F00, 0, 0, 1, "R3 max backward"));
    // R5 codes 14/15 and non-branch
    send(16'hDE05, 32'h200, 4'hF, 0, 0, mk(0, 32'h1FE, 0, 0, 1, "R5 code 14"));
    send(16'hDF05, 32'h200, 4'hF, 0, 0, mk(0, 32'h1FE, 0, 0, 1, "R5 code 15"));
    send(16'h1234, 32'h300, 4'hF, 32'h55, 32'h77, mk(0, 32'h2FE, 0, 0, 1, "R5/R12 non-branch"));
    // R6
    send(16'hE3FF, 32'h4000, 0, 0, 0, mk(1, 32'h47FE, 0, 0, 1, "R6 forward"));
    send(16'hE400, 32'h4000, 0, 0, 0, mk(1, 32'h3800, 0, 0, 1, "R6 backward"));
    // R7 then R8 chained
    lr1 = 32'h8004 + 32'hFFFFF000;
    send(16'hF7FF, 32'h8004, 0, 32'hDEAD, 0, mk(0, 32'h8002, 1, lr1, 1, "R7 negative"));
    send(16'hF800 | 16'h0123, 32'h8006, 0, lr1, 0,
         mk(1, lr1 + 32'h246, 1, 32'h8005, 1, "R8 chained"));
    send(16'hF3FF, 32'h10, 0, 0, 0, mk(0, 32'hE, 1, 32'h3FF010, 1, "R7 positive"));
    send(16'hFFFF, 32'h10, 0, 32'h100000, 0, mk(1, 32'h100FFE, 1, 32'h0F, 1, "R8 max field"));
    // R9 register source
    send(16'h4718, 32'h500, 0, 0, 32'h3001, mk(1, 32'h3000, 0, 0, 1, "R9 stays compact"));
    send(16'h4760, 32'h500, 0, 0, 32'h2002, mk(1, 32'h2002, 0, 0, 0, "R9 to wide mode"));
    // R10 pc source ignores in_reg
    send(16'h4778, 32'h207, 0, 0, 32'hAAAA5555, mk(1, 32'h204, 0, 0, 1, "R10 pc source"));
    send(16'h4778, 32'h20A, 0, 0, 32'h1, mk(1, 32'h208, 0, 0, 0, "R10 pc source even"));
    // R2 idle gap: nothing expected
    repeat (5) @(negedge clk);
    checks++;
    if (q.size() != 0 || out_valid !== 0) begin
      errors++;
      $display("FAIL R2 actual pending=%0d valid=%0b expected 0 0", q.size(), out_valid);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule